// File: doc/BRIEF.md
# Selectable Multi-Set Synthesizer Configuration Bank

This block stores four complete frequency-synthesizer setups. Each setup has a pre-divider, an integer feedback term, an 18-bit fractional feedback term and a post-divider. Two more fields are shared by all setups: a control-voltage gain and a control-voltage polarity. Every field comes up with a value fixed by a module parameter. The whole bank, including the shared fields, goes back to those values on every reset.

A host writes and reads the bank through a byte-wide register port. Each setup takes eight consecutive byte addresses. Two select inputs pick the setup that drives the synthesizer outputs. The selection path holds no register, so a change on the select pins shows at the outputs in the same cycle.

The fractional term spans three bytes. Its lower two bytes are held in a staging register. The setup is updated only when the top byte is written, so a setup in use never shows a half-written fraction. The intended sequence is to load a setup that is not selected and then move the select pins to it.

Top module: `synth_cfg_bank`

## Requirements
- R1: While reset is low at a clock edge, all four setups and the shared gain and polarity load their parameter defaults.
- R2: Select value 0, 1, 2 or 3 routes setup 0, 1, 2 or 3 to out_p, out_mint, out_mfrac and out_n.
- R3: A change on sel shows at the setup outputs without waiting for a clock edge.
- R4: Setup k takes addresses 8k to 8k+7. Offset 0 holds P in bits [1:0]. Offset 1 holds MINT in bits [6:0]. Offsets 2, 3 and 4 hold MFRAC, least significant byte first, with offset 4 holding MFRAC[17:16] in bits [1:0]. Offset 5 holds N in bits [6:0]. A write takes effect at the clock edge where wr_en is sampled high.
- R5: Address 0x20 holds the gain in bits [5:0] and address 0x21 holds the polarity in bit 0. Their outputs change only on a write to that address.
- R6: Writes to MFRAC offsets 2 and 3 of any setup go into one shared 16-bit staging register, and no setup's MFRAC changes. A write to offset 4 replaces all 18 bits of that setup's MFRAC at once: the write data forms bits [17:16] and the staging register forms bits [15:0].
- R7: When rd_en is high at a clock edge, rd_data holds the addressed byte and rd_valid is high during the following cycle. rd_valid is low after any cycle without rd_en. MFRAC bytes read back the committed value, not the staging register.
- R8: Offsets 6 and 7 of each setup and addresses 0x22 to 0x3F read as zero, and writes to them change no field.
- R9: A write to a setup that is not selected leaves the setup outputs unchanged.
- R10: Write-data bits above a field's width are dropped, and those bits read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; reloads defaults |
| sel | input | 2 | Select for the live setup |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write byte address |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 6 | Read byte address |
| rd_data | output | 8 | Read byte, valid with rd_valid |
| rd_valid | output | 1 | High the cycle after a read strobe |
| out_p | output | 2 | Pre-divider of the selected setup |
| out_mint | output | 7 | Feedback integer of the selected setup |
| out_mfrac | output | 18 | Feedback fraction of the selected setup |
| out_n | output | 7 | Post-divider of the selected setup |
| out_gain | output | 6 | Shared control-voltage gain |
| out_pol | output | 1 | Shared control-voltage polarity |

## Verification
The output-stability property assumes that sel holds steady between the clock edges at which it is compared. It also assumes that a write to the selected setup is the only thing that may change the outputs while sel holds. The reset-default properties assume that reset is held low for at least one clock edge before it is released. The bench drives every input just after a falling edge. It moves sel only when it intends a switch, and it starts with a reset lasting several cycles. Each MFRAC update is staged in the documented order: offset 2, then offset 3, then offset 4.

// File: rtl/synth_cfg_pkg.sv
// Package: widths, address map and setup record shared by the bank.
// Assumes four setups with a two-bit select and a byte-wide host port.
package synth_cfg_pkg;
    localparam int NUM_SETS   = 4;
    localparam int SEL_W      = $clog2(NUM_SETS);
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 6;
    localparam int SET_STRIDE = 8;
    localparam int OFS_W      = $clog2(SET_STRIDE);
    localparam int P_W        = 2;
    localparam int MINT_W     = 7;
    localparam int MFRAC_W    = 18;
    localparam int N_W        = 7;
    localparam int GAIN_W     = 6;
    localparam int STAGE_W    = 2 * DATA_W;
    localparam int FR_HI_W    = MFRAC_W - STAGE_W;

    localparam logic [ADDR_W-1:0] SET_SPACE = ADDR_W'(NUM_SETS * SET_STRIDE);
    localparam logic [ADDR_W-1:0] ADR_GAIN  = SET_SPACE;
    localparam logic [ADDR_W-1:0] ADR_POL   = SET_SPACE + ADDR_W'(1);

    localparam logic [OFS_W-1:0] OFS_P    = OFS_W'(0);
    localparam logic [OFS_W-1:0] OFS_MINT = OFS_W'(1);
    localparam logic [OFS_W-1:0] OFS_FR0  = OFS_W'(2);
    localparam logic [OFS_W-1:0] OFS_FR1  = OFS_W'(3);
    localparam logic [OFS_W-1:0] OFS_FR2  = OFS_W'(4);
    localparam logic [OFS_W-1:0] OFS_N    = OFS_W'(5);

    typedef struct packed {
        logic [P_W-1:0]     p;
        logic [MINT_W-1:0]  mint;
        logic [MFRAC_W-1:0] mfrac;
        logic [N_W-1:0]     n;
    } cfg_set_t;
endpackage

// File: rtl/cfg_set_reg.sv
// Module: storage for one synthesizer setup.
// Decodes host writes aimed at its own eight-byte window. MFRAC is committed
// as a whole when its top byte arrives, using the shared staging word.
// Assumes wr_addr below SET_SPACE for window hits (bit above window is zero).
module cfg_set_reg
    import synth_cfg_pkg::*;
#(
    parameter int       SET_IDX = 0,
    parameter cfg_set_t DEF     = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [STAGE_W-1:0] stage,
    output cfg_set_t           set_q
);
    localparam int WIN_W = ADDR_W - OFS_W;
    localparam logic [WIN_W-1:0] MY_WIN = WIN_W'(SET_IDX);

    logic             hit;
    logic [OFS_W-1:0] ofs;

    // Window decode for this setup.
    assign hit = wr_en && (wr_addr[ADDR_W-1:OFS_W] == MY_WIN);
    assign ofs = wr_addr[OFS_W-1:0];

    // Field storage: defaults on reset, byte writes otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q <= DEF;
        end else if (hit) begin
            case (ofs)
                OFS_P:    set_q.p     <= wr_data[P_W-1:0];
                OFS_MINT: set_q.mint  <= wr_data[MINT_W-1:0];
                OFS_FR2:  set_q.mfrac <= {wr_data[FR_HI_W-1:0], stage};
                OFS_N:    set_q.n     <= wr_data[N_W-1:0];
                default:  set_q       <= set_q;
            endcase
        end
    end

    AST_SET_RESET_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (set_q == DEF)); // R1
    AST_SET_HOLD_UNHIT: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(set_q)); // R9
    AST_MFRAC_NO_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (ofs == OFS_FR0 || ofs == OFS_FR1)) |=> $stable(set_q.mfrac)); // R6
endmodule

// File: rtl/cfg_out_sel.sv
// Module: live setup selector.
// Purely combinational so the synthesizer sees a select change at once.
// Assumes sel is a plain binary index into the setup array.
module cfg_out_sel
    import synth_cfg_pkg::*;
(
    input  cfg_set_t [NUM_SETS-1:0] sets,
    input  logic [SEL_W-1:0]        sel,
    output cfg_set_t                cfg
);
    // Route the indexed setup to the outputs.
    always_comb begin
        cfg = sets[sel];
    end
endmodule

// File: rtl/cfg_readback.sv
// Module: host read path.
// Builds the addressed byte from committed state and registers it with a
// one-cycle valid pulse. Unmapped addresses return zero.
// Assumes read address is sampled only when rd_en is high.
module cfg_readback
    import synth_cfg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  cfg_set_t [NUM_SETS-1:0] sets,
    input  logic [GAIN_W-1:0]       gain,
    input  logic                    pol,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    rd_valid
);
    cfg_set_t          cur;
    logic [DATA_W-1:0] rd_byte;
    logic [OFS_W-1:0]  ofs;

    assign ofs = rd_addr[OFS_W-1:0];

    // Byte builder over the address map.
    always_comb begin
        cur     = sets[rd_addr[OFS_W+SEL_W-1:OFS_W]];
        rd_byte = '0;
        if (rd_addr < SET_SPACE) begin
            case (ofs)
                OFS_P:    rd_byte = {{(DATA_W-P_W){1'b0}}, cur.p};
                OFS_MINT: rd_byte = {{(DATA_W-MINT_W){1'b0}}, cur.mint};
                OFS_FR0:  rd_byte = cur.mfrac[DATA_W-1:0];
                OFS_FR1:  rd_byte = cur.mfrac[STAGE_W-1:DATA_W];
                OFS_FR2:  rd_byte = {{(DATA_W-FR_HI_W){1'b0}}, cur.mfrac[MFRAC_W-1:STAGE_W]};
                OFS_N:    rd_byte = {{(DATA_W-N_W){1'b0}}, cur.n};
                default:  rd_byte = '0;
            endcase
        end else if (rd_addr == ADR_GAIN) begin
            rd_byte = {{(DATA_W-GAIN_W){1'b0}}, gain};
        end else if (rd_addr == ADR_POL) begin
            rd_byte = {{(DATA_W-1){1'b0}}, pol};
        end
    end

    // Read data and valid registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= rd_byte;
            end
        end
    end

    AST_RD_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R7
    AST_RD_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid); // R7
    AST_UNUSED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (((rd_addr < SET_SPACE) && (ofs > OFS_N)) || (rd_addr > ADR_POL)))
        |=> (rd_data == '0)); // R8
endmodule

// File: rtl/synth_cfg_bank.sv
// Module: top of the four-setup configuration bank.
// Holds the MFRAC staging word and the shared gain/polarity fields, and
// instantiates one storage block per setup, the live selector and the read path.
// Assumes a synchronous active-low reset held for at least one edge.
module synth_cfg_bank
    import synth_cfg_pkg::*;
#(
    parameter logic [NUM_SETS*P_W-1:0]     DEF_P     = {2'd3, 2'd2, 2'd1, 2'd0},
    parameter logic [NUM_SETS*MINT_W-1:0]  DEF_MINT  = {7'd20, 7'd19, 7'd18, 7'd17},
    parameter logic [NUM_SETS*MFRAC_W-1:0] DEF_MFRAC = {18'h30000, 18'h20000, 18'h10000, 18'h00000},
    parameter logic [NUM_SETS*N_W-1:0]     DEF_N     = {7'd24, 7'd16, 7'd12, 7'd8},
    parameter logic [GAIN_W-1:0]           DEF_GAIN  = 6'd16,
    parameter logic                        DEF_POL   = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     sel,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_valid,
    output logic [P_W-1:0]       out_p,
    output logic [MINT_W-1:0]    out_mint,
    output logic [MFRAC_W-1:0]   out_mfrac,
    output logic [N_W-1:0]       out_n,
    output logic [GAIN_W-1:0]    out_gain,
    output logic                 out_pol
);
    cfg_set_t [NUM_SETS-1:0] sets;
    cfg_set_t                live;
    logic [STAGE_W-1:0]      stage;
    logic                    in_sets;
    logic [OFS_W-1:0]        wofs;

    assign in_sets = wr_addr < SET_SPACE;
    assign wofs    = wr_addr[OFS_W-1:0];

    // Shared staging of the two low MFRAC bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
        end else if (wr_en && in_sets) begin
            if (wofs == OFS_FR0) stage[DATA_W-1:0]       <= wr_data;
            if (wofs == OFS_FR1) stage[STAGE_W-1:DATA_W] <= wr_data;
        end
    end

    // Shared control-voltage gain and polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_gain <= DEF_GAIN;
            out_pol  <= DEF_POL;
        end else if (wr_en) begin
            if (wr_addr == ADR_GAIN) out_gain <= wr_data[GAIN_W-1:0];
            if (wr_addr == ADR_POL)  out_pol  <= wr_data[0];
        end
    end

    for (genvar k = 0; k < NUM_SETS; k++) begin : g_set
        localparam cfg_set_t SET_DEF = '{
            p:     DEF_P[k*P_W +: P_W],
            mint:  DEF_MINT[k*MINT_W +: MINT_W],
            mfrac: DEF_MFRAC[k*MFRAC_W +: MFRAC_W],
            n:     DEF_N[k*N_W +: N_W]
        };
        cfg_set_reg #(
            .SET_IDX (k),
            .DEF     (SET_DEF)
        ) u_set (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .stage   (stage),
            .set_q   (sets[k])
        );
    end

    cfg_out_sel u_sel (
        .sets (sets),
        .sel  (sel),
        .cfg  (live)
    );

    assign out_p     = live.p;
    assign out_mint  = live.mint;
    assign out_mfrac = live.mfrac;
    assign out_n     = live.n;

    cfg_readback u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .sets     (sets),
        .gain     (out_gain),
        .pol      (out_pol),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    logic sel_wr;
    assign sel_wr = wr_en && in_sets && (wr_addr[OFS_W+SEL_W-1:OFS_W] == sel);

    AST_SHARED_RESET_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (out_gain == DEF_GAIN && out_pol == DEF_POL)); // R1
    AST_LIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_wr |=> (!$stable(sel) || $stable({out_p, out_mint, out_mfrac, out_n}))); // R9
    AST_GAIN_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == ADR_GAIN) |=> $stable(out_gain)); // R5
    AST_POL_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == ADR_POL) |=> $stable(out_pol)); // R5
endmodule

// File: tb/synth_cfg_bank_tb.sv
// Bench: scoreboard of expected read bytes plus direct output checks
// against a model built from the documented address map.
module synth_cfg_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  sel = 2'd0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [5:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [1:0]  out_p;
    logic [6:0]  out_mint;
    logic [17:0] out_mfrac;
    logic [6:0]  out_n;
    logic [5:0]  out_gain;
    logic        out_pol;

    always #5 clk = ~clk;

    synth_cfg_bank #(
        .DEF_P     ({2'd0, 2'd3, 2'd2, 2'd1}),
        .DEF_MINT  ({7'h7F, 7'h3A, 7'h44, 7'h50}),
        .DEF_MFRAC ({18'h3FFFF, 18'h05555, 18'h1ABCD, 18'h21234}),
        .DEF_N     ({7'h7E, 7'h20, 7'h10, 7'h0C}),
        .DEF_GAIN  (6'h2A),
        .DEF_POL   (1'b1)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .sel(sel),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .out_p(out_p), .out_mint(out_mint), .out_mfrac(out_mfrac), .out_n(out_n),
        .out_gain(out_gain), .out_pol(out_pol)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [1:0]  m_p [4];
    logic [6:0]  m_mint [4];
    logic [17:0] m_mfrac [4];
    logic [6:0]  m_n [4];
    logic [5:0]  m_gain;
    logic        m_pol;
    logic [15:0] m_stage;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_p     = '{2'd1, 2'd2, 2'd3, 2'd0};
        m_mint  = '{7'h50, 7'h44, 7'h3A, 7'h7F};
        m_mfrac = '{18'h21234, 18'h1ABCD, 18'h05555, 18'h3FFFF};
        m_n     = '{7'h0C, 7'h10, 7'h20, 7'h7E};
        m_gain  = 6'h2A;
        m_pol   = 1'b1;
        m_stage = '0;
    endtask

    function automatic logic [7:0] model_byte(logic [5:0] a);
        int k = a[4:3];
        if (a < 6'd32) begin
            case (a[2:0])
                3'd0: return {6'd0, m_p[k]};
                3'd1: return {1'b0, m_mint[k]};
                3'd2: return m_mfrac[k][7:0];
                3'd3: return m_mfrac[k][15:8];
                3'd4: return {6'd0, m_mfrac[k][17:16]};
                3'd5: return {1'b0, m_n[k]};
                default: return 8'd0;
            endcase
        end
        if (a == 6'd32) return {2'd0, m_gain};
        if (a == 6'd33) return {7'd0, m_pol};
        return 8'd0;
    endfunction

    task automatic do_write(logic [5:0] a, logic [7:0] d);
        int k = a[4:3];
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 6'd32) begin
            case (a[2:0])
                3'd0: m_p[k] = d[1:0];
                3'd1: m_mint[k] = d[6:0];
                3'd2: m_stage[7:0] = d;
                3'd3: m_stage[15:8] = d;
                3'd4: m_mfrac[k] = {d[1:0], m_stage};
                3'd5: m_n[k] = d[6:0];
                default: ;
            endcase
        end else if (a == 6'd32) m_gain = d[5:0];
        else if (a == 6'd33) m_pol = d[0];
    endtask

    // Driver: push the expected byte, then strobe the read.
    task automatic do_read(logic [5:0] a, string req);
        @(negedge clk);
        exp_q.push_back(model_byte(a));
        tag_q.push_back(req);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic check_live(string req);
        chk(req, "out_p", 32'(out_p), 32'(m_p[sel]));
        chk(req, "out_mint", 32'(out_mint), 32'(m_mint[sel]));
        chk(req, "out_mfrac", 32'(out_mfrac), 32'(m_mfrac[sel]));
        chk(req, "out_n", 32'(out_n), 32'(m_n[sel]));
    endtask

    task automatic check_shared(string req);
        chk(req, "out_gain", 32'(out_gain), 32'(m_gain));
        chk(req, "out_pol", 32'(out_pol), 32'(m_pol));
    endtask

    // Monitor: pop and compare each valid read byte.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R7", "unexpected rd_valid", 32'(1), 32'(0));
            end else begin
                chk(tag_q.pop_front(), "rd_data", 32'(rd_data), 32'(exp_q.pop_front()));
            end
        end
    end

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL all: watchdog expired, actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1, R2, R3: defaults per select value, switched between edges
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            #2 sel = 2'(s);
            #1 check_live("R2");
        end
        check_shared("R1");
        chk("R7", "rd_valid idle", 32'(rd_valid), 32'(0));
        // R4, R7: read back the whole map of every setup
        for (int a = 0; a < 32; a++) begin
            if (a[2:0] <= 3'd5) do_read(6'(a), "R4");
        end
        do_read(6'd32, "R5");
        do_read(6'd33, "R5");
        // R9: rewrite setup 2 while setup 0 is live
        sel = 2'd0;
        do_write(6'h10, 8'h02);
        do_write(6'h11, 8'h11);
        do_write(6'h12, 8'h9A);
        do_write(6'h13, 8'hBC);
        do_write(6'h14, 8'h01);
        do_write(6'h15, 8'h33);
        check_live("R9");
        #2 sel = 2'd2;
        #1 check_live("R3");
        // R6: partial MFRAC writes on the live setup do not move it
        do_write(6'h12, 8'h77);
        chk("R6", "mfrac after byte0", 32'(out_mfrac), 32'(18'h1BC9A));
        do_write(6'h13, 8'h66);
        chk("R6", "mfrac after byte1", 32'(out_mfrac), 32'(18'h1BC9A));
        do_read(6'h12, "R6");
        do_read(6'h13, "R6");
        do_write(6'h14, 8'h02);
        chk("R6", "mfrac commit", 32'(out_mfrac), 32'(18'h26677));
        do_read(6'h14, "R6");
        // R10: wide data into narrow fields
        do_write(6'h08, 8'hFF);
        do_read(6'h08, "R10");
        do_write(6'h1D, 8'hFF);
        do_write(6'h1A, 8'h00);
        do_write(6'h1B, 8'h00);
        do_write(6'h1C, 8'hFF);
        #2 sel = 2'd3;
        #1 check_live("R10");
        chk("R10", "mfrac top only", 32'(out_mfrac), 32'(18'h30000));
        // R8: unused addresses ignore writes and read zero
        #2 sel = 2'd1;
        do_write(6'h0E, 8'hAA);
        do_write(6'h0F, 8'h55);
        do_write(6'h25, 8'h3C);
        do_write(6'h3F, 8'hC3);
        #1 check_live("R8");
        check_shared("R8");
        do_read(6'h0E, "R8");
        do_read(6'h0F, "R8");
        do_read(6'h25, "R8");
        do_read(6'h3F, "R8");
        for (int a = 8; a < 14; a++) do_read(6'(a), "R8");
        // R5: shared fields, with R10 truncation
        do_write(6'h20, 8'hC5);
        chk("R5", "gain write", 32'(out_gain), 32'(6'h05));
        do_write(6'h21, 8'hFE);
        chk("R5", "pol write", 32'(out_pol), 32'(1'b0));
        do_read(6'h20, "R10");
        do_read(6'h21, "R5");
        // R1: a second reset restores every default
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        for (int s = 0; s < 4; s++) begin
            #2 sel = 2'(s);
            #1 check_live("R1");
        end
        check_shared("R1");
        do_read(6'h14, "R1");
        repeat (3) @(negedge clk);
        chk("R7", "scoreboard drained", 32'(exp_q.size()), 32'(0));
        done = 1'b1;
        finish_run();
    end
endmodule